// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block predicts the direction and destination of branches for an instruction fetch unit. It keeps a small fully associative table of recently taken branches. Each entry records the address of the branch instruction, the address it last jumped to, and a two-bit history counter. The table lives in dedicated registers inside the predictor, not in main memory. The fetch unit presents its current address on the lookup port and, in the same cycle, receives a hit flag, a taken or not-taken prediction and a predicted target. An address that is not in the table is predicted not taken, so fetch continues sequentially.

When a branch resolves later in the pipeline, its address, real outcome and real target arrive on the update port. A resident entry moves its counter one step toward the outcome and takes on a new target if that target differs. A taken branch that is not resident is written into the slot chosen by a round-robin pointer. Because of the counter's hysteresis, a strongly biased branch, such as the back edge of a loop, is mispredicted only once when it goes the other way one time. A one-bit mode is provided for comparison. In that mode the prediction simply repeats the branch's last outcome.

Top module: `brpred_table`

## Requirements
- R1: After reset every entry is empty: every lookup reports hit=0, prediction not taken and target 0.
- R2: A lookup whose address matches no valid entry drives hit=0, taken=0 and target=0 in the same cycle as the address.
- R3: An update for an address that is not in the table allocates an entry only if the outcome is taken. A not-taken update on a miss leaves the table unchanged.
- R4: A newly allocated entry stores the branch address and its target and starts in the weak-taken state 2'b10. The next lookup of that address therefore hits and predicts taken with the stored target.
- R5: In two-bit mode the counter steps 00→01→10→11 on taken outcomes and 11→10→01→00 on not-taken outcomes, and saturates at both ends. The prediction is taken exactly when the counter's upper bit is 1, that is, in states 10 and 11.
- R6: An entry in the strong-taken state 11 still predicts taken after a single not-taken outcome.
- R7: A taken update that hits an entry replaces the stored target with the update's target.
- R8: A not-taken update that hits an entry keeps the entry and leaves its stored target unchanged.
- R9: Allocation uses a round-robin pointer over all DEPTH slots. With a full table, the next allocation evicts the entry allocated DEPTH allocations earlier, and the other entries stay resident.
- R10: A lookup and an update to the same entry in the same cycle return the state from before the update. The new state appears on lookups from the following cycle.
- R11: With ONE_BIT=1 the prediction is the last resolved outcome of the branch: a taken outcome sets the state to 11, a not-taken outcome sets it to 00, and a new entry starts at 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | AW | Fetch address to look up |
| lk_hit | output | 1 | Lookup address is resident |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | AW | Predicted target (0 on a miss) |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | AW | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the branch |
| up_target | input | AW | Actual target of the branch |

## Verification
Lookup results are combinational, so they are due in the same cycle that the address is presented. The bench changes the lookup address after a falling edge and samples one time step later, before the next rising edge. An update is sampled on the rising edge that follows its presentation. Its effect is therefore first checked at the next falling edge. The same-cycle case holds an update and a lookup of the same address together and checks both the old prediction, before the edge, and the new one, after it. Saturation, hysteresis, eviction order and the one-bit mode are each checked through sequences of updates whose predicted outcomes are worked out step by step in the bench.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

   typedef logic [1:0] hist_t;

   localparam hist_t H_SNT = 2'b00;  // strongly not taken
   localparam hist_t H_WNT = 2'b01;  // weakly not taken
   localparam hist_t H_WT  = 2'b10;  // weakly taken
   localparam hist_t H_ST  = 2'b11;  // strongly taken

   // saturating step toward the resolved outcome
   function automatic hist_t hist_step(hist_t s, logic taken);
      if (taken) return (s == H_ST) ? s : hist_t'(s + 2'd1);
      return (s == H_SNT) ? s : hist_t'(s - 2'd1);
   endfunction

endpackage

// File: rtl/brpred_cam.sv
module brpred_cam #(
   parameter int AW    = 16,
   parameter int DEPTH = 16,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [DEPTH-1:0]         valid,
   input  logic [DEPTH-1:0][AW-1:0] tags,
   input  logic [AW-1:0]            key,
   output logic [DEPTH-1:0]         match,
   output logic                     hit,
   output logic [IW-1:0]            idx
);

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_cmp
         assign match[g] = valid[g] && (tags[g] == key);
      end
   endgenerate

   assign hit = |match;

   always_comb begin
      idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (match[i]) idx = idx | IW'(i);
      end
   end

endmodule

// File: rtl/brpred_rr.sv
module brpred_rr #(
   parameter int DEPTH = 16,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   output logic [IW-1:0] ptr
);

   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

endmodule

// File: rtl/brpred_table.sv
module brpred_table
   import brpred_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DEPTH   = 16,
   parameter bit ONE_BIT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] lk_pc,
   output logic          lk_hit,
   output logic          lk_taken,
   output logic [AW-1:0] lk_target,
   input  logic          up_valid,
   input  logic [AW-1:0] up_pc,
   input  logic          up_taken,
   input  logic [AW-1:0] up_target
);

   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2)   $error("brpred_table: DEPTH must be at least 2");
      if (AW < 2)      $error("brpred_table: AW must be at least 2");
      if (DEPTH > 256) $error("brpred_table: DEPTH too large for a CAM");
   endgenerate

   logic [DEPTH-1:0]         valid_q;
   logic [DEPTH-1:0][AW-1:0] pc_q;
   logic [DEPTH-1:0][AW-1:0] tgt_q;
   hist_t [DEPTH-1:0]        hist_q;

   logic [DEPTH-1:0] lk_match, up_match;
   logic             lk_hit_c, up_hit;
   logic [IW-1:0]    lk_idx, up_idx, rr_ptr;
   logic             alloc_en;
   hist_t            hist_cur, hist_nx, hist_init;

   brpred_cam #(.AW(AW), .DEPTH(DEPTH)) u_lk_cam (
      .valid(valid_q), .tags(pc_q), .key(lk_pc),
      .match(lk_match), .hit(lk_hit_c), .idx(lk_idx));

   brpred_cam #(.AW(AW), .DEPTH(DEPTH)) u_up_cam (
      .valid(valid_q), .tags(pc_q), .key(up_pc),
      .match(up_match), .hit(up_hit), .idx(up_idx));

   assign alloc_en = up_valid && !up_hit && up_taken;

   brpred_rr #(.DEPTH(DEPTH)) u_rr (
      .clk(clk), .rst_n(rst_n), .advance(alloc_en), .ptr(rr_ptr));

   assign hist_cur = hist_q[up_idx];

   generate
      if (ONE_BIT) begin : g_last_outcome
         assign hist_nx   = up_taken ? H_ST : H_SNT;
         assign hist_init = H_ST;
      end else begin : g_two_bit
         assign hist_nx   = hist_step(hist_cur, up_taken);
         assign hist_init = H_WT;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         pc_q    <= '0;
         tgt_q   <= '0;
         hist_q  <= '0;
      end else if (up_valid) begin
         if (up_hit) begin
            hist_q[up_idx] <= hist_nx;
            if (up_taken && (tgt_q[up_idx] != up_target))
               tgt_q[up_idx] <= up_target;
         end else if (alloc_en) begin
            valid_q[rr_ptr] <= 1'b1;
            pc_q[rr_ptr]    <= up_pc;
            tgt_q[rr_ptr]   <= up_target;
            hist_q[rr_ptr]  <= hist_init;
         end
      end
   end

   assign lk_hit    = lk_hit_c;
   assign lk_taken  = lk_hit_c && hist_q[lk_idx][1];
   assign lk_target = lk_hit_c ? tgt_q[lk_idx] : '0;

   // ---------------- assertions ----------------
   assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match) && $onehot0(up_match));

   assert_valid_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(valid_q) >= $countones($past(valid_q)));

   assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (!lk_taken && lk_target == '0));

   assert_rr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_en |=> $stable(rr_ptr));

   genvar e;
   generate
      for (e = 0; e < DEPTH; e++) begin : g_chk
         if (ONE_BIT) begin : g_c1
            assert_onebit_states_R11: assert property (@(posedge clk) disable iff (!rst_n)
               hist_q[e] == H_SNT || hist_q[e] == H_ST);
         end else begin : g_c2
            assert_strong_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
               hist_q[e] == H_ST |=> hist_q[e][1]);
         end
      end
   endgenerate

endmodule

// File: tb/sim_brpred_table.sv
module sim_brpred_table;

   localparam int AW = 16;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] lk_pc = '0;
   logic          up_valid = 1'b0;
   logic [AW-1:0] up_pc = '0;
   logic          up_taken = 1'b0;
   logic [AW-1:0] up_target = '0;

   logic          h0, t0, h1, t1;
   logic [AW-1:0] g0, g1;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   brpred_table #(.AW(AW), .DEPTH(DEPTH), .ONE_BIT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(h0), .lk_taken(t0),
      .lk_target(g0), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_target(up_target));

   brpred_table #(.AW(AW), .DEPTH(DEPTH), .ONE_BIT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(h1), .lk_taken(t1),
      .lk_target(g1), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_target(up_target));

   // compare the current lookup result of one instance
   task automatic expect_lk(input bit sel, input logic eh, input logic et,
                            input logic [AW-1:0] eg, input string req);
      logic ah, at;
      logic [AW-1:0] ag;
      ah = sel ? h1 : h0;
      at = sel ? t1 : t0;
      ag = sel ? g1 : g0;
      total++;
      if (ah !== eh || at !== et || ag !== eg) begin
         bad++;
         $display("FAIL %s pc=%h: got hit=%b taken=%b tgt=%h, want hit=%b taken=%b tgt=%h",
                  req, lk_pc, ah, at, ag, eh, et, eg);
      end
   endtask

   task automatic look(input bit sel, input logic [AW-1:0] pc, input logic eh,
                       input logic et, input logic [AW-1:0] eg, input string req);
      lk_pc = pc;
      #1;
      expect_lk(sel, eh, et, eg, req);
   endtask

   task automatic upd(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tg);
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tg;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic t_reset;
      look(0, 16'h0100, 0, 0, 16'h0000, "R1");
      look(0, 16'h0000, 0, 0, 16'h0000, "R1");
   endtask

   task automatic t_alloc;
      upd(16'h0040, 1'b0, 16'h0400);
      look(0, 16'h0040, 0, 0, 16'h0000, "R3");
      upd(16'h0040, 1'b1, 16'h0400);
      look(0, 16'h0040, 1, 1, 16'h0400, "R4");
      look(0, 16'h0044, 0, 0, 16'h0000, "R2");
      upd(16'h0040, 1'b0, 16'h0999);      // 10 -> 01
      look(0, 16'h0040, 1, 0, 16'h0400, "R8");
   endtask

   task automatic t_counter;
      upd(16'h0040, 1'b1, 16'h0400);      // 01 -> 10
      look(0, 16'h0040, 1, 1, 16'h0400, "R5");
      upd(16'h0040, 1'b1, 16'h0400);      // 11
      upd(16'h0040, 1'b1, 16'h0400);      // stays 11
      upd(16'h0040, 1'b0, 16'h0400);      // 10
      look(0, 16'h0040, 1, 1, 16'h0400, "R6");
      upd(16'h0040, 1'b0, 16'h0400);      // 01
      look(0, 16'h0040, 1, 0, 16'h0400, "R5");
      upd(16'h0040, 1'b0, 16'h0400);      // 00
      upd(16'h0040, 1'b0, 16'h0400);      // stays 00
      upd(16'h0040, 1'b1, 16'h0400);      // 01
      look(0, 16'h0040, 1, 0, 16'h0400, "R5");
   endtask

   task automatic t_retarget;
      upd(16'h0040, 1'b1, 16'h0500);      // 10, new target
      look(0, 16'h0040, 1, 1, 16'h0500, "R7");
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      up_valid = 1'b1; up_pc = 16'h0040; up_taken = 1'b0; up_target = 16'h0500;
      look(0, 16'h0040, 1, 1, 16'h0500, "R10");
      @(negedge clk);
      up_valid = 1'b0;
      look(0, 16'h0040, 1, 0, 16'h0500, "R10");
   endtask

   task automatic t_replace;
      // slot 0 holds 0x0040; fill slots 1..15
      for (int i = 1; i < DEPTH; i++) upd(16'h1000 + 16'(i), 1'b1, 16'h2000 + 16'(i));
      look(0, 16'h0040, 1, 0, 16'h0500, "R9");
      for (int i = 1; i < DEPTH; i++) look(0, 16'h1000 + 16'(i), 1, 1, 16'h2000 + 16'(i), "R9");
      upd(16'h3000, 1'b1, 16'h3100);     // evicts slot 0
      look(0, 16'h0040, 0, 0, 16'h0000, "R9");
      look(0, 16'h3000, 1, 1, 16'h3100, "R9");
      look(0, 16'h1001, 1, 1, 16'h2001, "R9");
      upd(16'h3001, 1'b1, 16'h3101);     // evicts slot 1
      look(0, 16'h1001, 0, 0, 16'h0000, "R9");
      look(0, 16'h1002, 1, 1, 16'h2002, "R9");
      look(0, 16'h3001, 1, 1, 16'h3101, "R9");
   endtask

   task automatic t_one_bit;
      upd(16'h7000, 1'b1, 16'h7100);
      look(1, 16'h7000, 1, 1, 16'h7100, "R11");
      upd(16'h7000, 1'b1, 16'h7100);
      upd(16'h7000, 1'b0, 16'h7100);
      look(1, 16'h7000, 1, 0, 16'h7100, "R11");
      look(0, 16'h7000, 1, 1, 16'h7100, "R6");   // two-bit 11 -> 10 still taken
      upd(16'h7000, 1'b1, 16'h7100);
      look(1, 16'h7000, 1, 1, 16'h7100, "R11");
   endtask

   initial begin
      #(20 * 100000);
      bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alloc();
      t_counter();
      t_retarget();
      t_same_cycle();
      t_replace();
      t_one_bit();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule